// File: doc/BRIEF.md
# Dual-Line Masked Interrupt Status Controller

This block gathers one-cycle event pulses from a storage-card host's command and data engines and holds each in a sticky status bit. Next to those bits, the same status word carries a group of level flags that show the present state of the transfer FIFO. Software reads the whole word at one address. It clears sticky bits by writing ones to a second address. It programs two separate enable masks at two more addresses.

Two interrupt lines are driven from the one status word. Each line is the OR of the status bits enabled by its own mask. The usual setup enables completion and error events on the first line and FIFO service flags on the second. With that setup, a programmed-I/O handler and a completion handler can run on different vectors.

The bus side has a word-wide write port and a read port with one cycle of read latency. The register is selected by a two-bit address. The sources of the event pulses and of the live flags sit outside this block.

Top module: `isr_dual_line`

## Requirements
- R1: Synchronous reset clears every sticky bit, both masks and both interrupt outputs, so that reading status, mask 0 or mask 1 returns zero after reset.
- R2: A one-cycle pulse on `evt_set[i]` sets status bit i (for i below STICKY_W). That bit stays set until a clear write removes it.
- R3: A write to address 1 clears exactly the sticky bits whose data bit is one and leaves the other sticky bits unchanged. Writing all ones clears every sticky bit.
- R4: If a sticky bit receives an event pulse in the same cycle that a clear write targets it, the bit ends up set.
- R5: Status bits STICKY_W and above show `live_in`, registered once, in every cycle. A clear write has no effect on them.
- R6: `irq_done` is a register. It is high exactly when the status word ANDed with mask 0 (address 2) was nonzero in the previous cycle.
- R7: `irq_fifo` is a register. It is high exactly when the status word ANDed with mask 1 (address 3) was nonzero in the previous cycle.
- R8: A write to address 2 or 3 stores the low STAT_W data bits in that mask. Reading the same address returns the stored value, and reading address 1 returns zero. Address 0 is the status word. Read data appears on `bus_rdata` one clock after the address is presented.
- R9: When a clear or mask write removes the last enabled cause of an interrupt, the line stays high through the clock edge that captures the write. It falls on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | STICKY_W | One-cycle event pulses, one per sticky status bit |
| live_in | input | LIVE_W | Level flags from the FIFO, shown live in the status word |
| bus_addr | input | 2 | Register select: 0 status, 1 clear, 2 mask 0, 3 mask 1 |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq_done | output | 1 | Interrupt line 0, enabled by mask 0 |
| irq_fifo | output | 1 | Interrupt line 1, enabled by mask 1 |

## Verification
The hardest case to create from the ports is a clear write and a new event hitting the same sticky bit in one cycle. A sequential handler never produces it, so the stimulus drives the event pulse and the clear strobe together at one edge. It then reads the bit back.

The one-edge lag of the interrupt after a clear is also checked. The lines are sampled both right after the write edge, when they must still be high, and one edge later, when they must be low.

The live flags are swept through all their combinations against a sparse mask on line 1. A global clear is then issued while the flags are held, to show that they survive it.

// File: rtl/isr_pkg.sv
package isr_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_CLEAR  = 2'd1,
    REG_MASK0  = 2'd2,
    REG_MASK1  = 2'd3
  } isr_reg_e;

  localparam int unsigned NUM_LINES = 2;
endpackage

// File: rtl/isr_status_word.sv
module isr_status_word #(
  parameter int unsigned STICKY_W = 10,
  parameter int unsigned LIVE_W   = 6,
  localparam int unsigned STAT_W  = STICKY_W + LIVE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [STICKY_W-1:0] set_i,
  input  logic [STICKY_W-1:0] clr_i,
  input  logic [LIVE_W-1:0]   live_i,
  output logic [STAT_W-1:0]   status_o
);
  logic [STICKY_W-1:0] sticky_q;
  logic [LIVE_W-1:0]   live_q;

  for (genvar b = 0; b < STICKY_W; b++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst)           sticky_q[b] <= 1'b0;
      else if (set_i[b]) sticky_q[b] <= 1'b1;
      else if (clr_i[b]) sticky_q[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) live_q <= '0;
    else     live_q <= live_i;
  end

  assign status_o = {live_q, sticky_q};
endmodule

// File: rtl/isr_mask_bank.sv
module isr_mask_bank #(
  parameter int unsigned STAT_W    = 16,
  parameter int unsigned NUM_LINES = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_LINES-1:0]                wr_i,
  input  logic [STAT_W-1:0]                   wdata_i,
  output logic [NUM_LINES-1:0][STAT_W-1:0]    mask_o
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)         mask_o[l] <= '0;
      else if (wr_i[l]) mask_o[l] <= wdata_i;
    end
  end
endmodule

// File: rtl/isr_irq_line.sv
module isr_irq_line #(
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] status_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic              irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_i & mask_i);
  end
endmodule

// File: rtl/isr_dual_line.sv
module isr_dual_line
  import isr_pkg::*;
#(
  parameter int unsigned STICKY_W = 10,
  parameter int unsigned LIVE_W   = 6,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [STICKY_W-1:0] evt_set,
  input  logic [LIVE_W-1:0]   live_in,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_done,
  output logic                irq_fifo
);
  localparam int unsigned STAT_W = STICKY_W + LIVE_W;

  logic [STAT_W-1:0]                 status_w;
  logic [NUM_LINES-1:0][STAT_W-1:0]  mask_w;
  logic [NUM_LINES-1:0]              mask_wr;
  logic [NUM_LINES-1:0]              irq_w;
  logic [STICKY_W-1:0]               clr_w;
  logic [STAT_W-1:0]                 rd_mux;

  assign clr_w = (bus_wr && bus_addr == REG_CLEAR) ? bus_wdata[STICKY_W-1:0] : '0;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_sel
    assign mask_wr[l] = bus_wr && (bus_addr == 2'(REG_MASK0 + l));
  end

  isr_status_word #(.STICKY_W(STICKY_W), .LIVE_W(LIVE_W)) u_status (
    .clk(clk), .rst(rst), .set_i(evt_set), .clr_i(clr_w),
    .live_i(live_in), .status_o(status_w)
  );

  isr_mask_bank #(.STAT_W(STAT_W), .NUM_LINES(NUM_LINES)) u_masks (
    .clk(clk), .rst(rst), .wr_i(mask_wr),
    .wdata_i(bus_wdata[STAT_W-1:0]), .mask_o(mask_w)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_irq
    isr_irq_line #(.STAT_W(STAT_W)) u_line (
      .clk(clk), .rst(rst), .status_i(status_w),
      .mask_i(mask_w[l]), .irq_o(irq_w[l])
    );
  end

  assign irq_done = irq_w[0];
  assign irq_fifo = irq_w[1];

  always_comb begin
    unique case (bus_addr)
      REG_STATUS: rd_mux = status_w;
      REG_MASK0:  rd_mux = mask_w[0];
      REG_MASK1:  rd_mux = mask_w[1];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= DATA_W'(rd_mux);
  end

  if (DATA_W > STAT_W) begin : g_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:STAT_W];
  end
endmodule

// File: rtl/isr_dual_line_chk.sv
module isr_dual_line_chk #(
  parameter int unsigned STICKY_W = 10,
  parameter int unsigned LIVE_W   = 6,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned STAT_W  = STICKY_W + LIVE_W
) (
  input logic                clk,
  input logic                rst,
  input logic [STICKY_W-1:0] evt_set,
  input logic [LIVE_W-1:0]   live_in,
  input logic [1:0]          bus_addr,
  input logic                bus_wr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [STAT_W-1:0]   status_q,
  input logic [STAT_W-1:0]   mask0,
  input logic [STAT_W-1:0]   mask1,
  input logic                irq_done,
  input logic                irq_fifo
);
  logic clr_wr;
  assign clr_wr = bus_wr && bus_addr == 2'd1;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!irq_done && !irq_fifo && mask0 == '0 && mask1 == '0)); // R1

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && !clr_wr) |=> ((status_q[STICKY_W-1:0] & $past(status_q[STICKY_W-1:0]))
                          == $past(status_q[STICKY_W-1:0]))); // R2

  AST_CLEAR_HITS: assert property (@(posedge clk) disable iff (rst)
    (!rst && clr_wr) |=> ((status_q[STICKY_W-1:0]
                          & $past(bus_wdata[STICKY_W-1:0] & ~evt_set)) == '0)); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (!rst && |evt_set) |=> ((status_q[STICKY_W-1:0] & $past(evt_set)) == $past(evt_set))); // R4

  AST_LIVE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (status_q[STAT_W-1:STICKY_W] == $past(live_in))); // R5

  AST_LINE0_MASKED: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_done == |($past(status_q) & $past(mask0)))); // R6

  AST_LINE1_MASKED: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_fifo == |($past(status_q) & $past(mask1)))); // R7

  AST_MASK_STORE: assert property (@(posedge clk) disable iff (rst)
    (!rst && bus_wr && bus_addr == 2'd2) |=> (mask0 == $past(bus_wdata[STAT_W-1:0]))); // R8
endmodule

bind isr_dual_line isr_dual_line_chk #(
  .STICKY_W(STICKY_W), .LIVE_W(LIVE_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .evt_set(evt_set), .live_in(live_in),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .status_q(status_w), .mask0(mask_w[0]), .mask1(mask_w[1]),
  .irq_done(irq_done), .irq_fifo(irq_fifo)
);

// File: tb/test_isr_dual_line.sv
module test_isr_dual_line;
  localparam int SW = 10;
  localparam int LW = 6;
  localparam int DW = 32;

  logic          clk = 0;
  logic          rst = 1;
  logic [SW-1:0] evt_set = '0;
  logic [LW-1:0] live_in = '0;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_done, irq_fifo;

  int n_run = 0;
  int n_fail = 0;
  logic [DW-1:0] rd;

  always #5 clk = ~clk;

  isr_dual_line #(.STICKY_W(SW), .LIVE_W(LW), .DATA_W(DW)) i_isr_dual_line (
    .clk(clk), .rst(rst), .evt_set(evt_set), .live_in(live_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_done(irq_done), .irq_fifo(irq_fifo)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic pulse(logic [SW-1:0] e);
    @(negedge clk); evt_set = e;
    @(negedge clk); evt_set = '0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 irq_done", DW'(irq_done), 0);
    check("R1 irq_fifo", DW'(irq_fifo), 0);
    rd_reg(0, rd); check("R1 status", rd, 0);
    rd_reg(2, rd); check("R1 mask0", rd, 0);
    rd_reg(3, rd); check("R1 mask1", rd, 0);

    // R8 mask storage and clear-register read
    wr_reg(2, 32'hFFFF_A5C3); rd_reg(2, rd); check("R8 mask0", rd, 32'h0000_A5C3);
    wr_reg(3, 32'h0000_3C5A); rd_reg(3, rd); check("R8 mask1", rd, 32'h0000_3C5A);
    rd_reg(1, rd); check("R8 clear reads zero", rd, 0);
    wr_reg(2, 0); wr_reg(3, 0);

    // R2 R6 R9 R3 per sticky bit
    for (int i = 0; i < SW; i++) begin
      pulse(SW'(1) << i);
      rd_reg(0, rd); check("R2 set", rd, DW'(1) << i);
      repeat (3) @(negedge clk);
      rd_reg(0, rd); check("R2 hold", rd, DW'(1) << i);
      check("R6 masked off", DW'(irq_done), 0);
      check("R7 masked off", DW'(irq_fifo), 0);
      wr_reg(2, DW'(1) << i); @(negedge clk);
      check("R6 enabled", DW'(irq_done), 1);
      wr_reg(2, ~(DW'(1) << i));
      check("R9 mask lag", DW'(irq_done), 1);
      @(negedge clk);
      check("R6 other bits", DW'(irq_done), 0);
      wr_reg(2, DW'(1) << i); @(negedge clk);
      wr_reg(1, DW'(1) << i);
      check("R9 clear lag", DW'(irq_done), 1);
      @(negedge clk);
      check("R9 clear fall", DW'(irq_done), 0);
      rd_reg(0, rd); check("R3 cleared", rd, 0);
      wr_reg(2, 0);
    end

    // R3 partial and full clear
    pulse('1);
    wr_reg(1, 32'h155);
    rd_reg(0, rd); check("R3 partial", rd, 32'h2AA);
    wr_reg(1, 32'hFFF);
    rd_reg(0, rd); check("R3 all", rd, 0);

    // R4 set and clear in the same cycle
    @(negedge clk);
    evt_set = SW'(10'h088); bus_addr = 1; bus_wr = 1; bus_wdata = 32'h3FF;
    @(negedge clk);
    evt_set = '0; bus_wr = 0; bus_wdata = '0;
    rd_reg(0, rd); check("R4 set wins", rd, 32'h088);
    wr_reg(1, 32'hFFF);

    // R5 R7 live-flag sweep against a sparse line-1 mask
    wr_reg(3, 32'h29 << SW);
    for (int v = 0; v < (1 << LW); v++) begin
      @(negedge clk); live_in = LW'(v);
      @(negedge clk);
      @(negedge clk);
      check("R7 live irq", DW'(irq_fifo), DW'(((v & 'h29) != 0) ? 1 : 0));
      check("R6 line0 quiet", DW'(irq_done), 0);
      rd_reg(0, rd); check("R5 live read", rd, DW'(v) << SW);
    end

    // R5 clear write ignored by live bits
    @(negedge clk); live_in = 6'h2D;
    wr_reg(1, 32'hFFFF_FFFF);
    rd_reg(0, rd); check("R5 clear ignored", rd, DW'(6'h2D) << SW);

    // R6 line 0 can also enable a live bit
    wr_reg(2, DW'(1) << (SW + 2)); @(negedge clk);
    check("R6 live on line0", DW'(irq_done), 1);
    @(negedge clk); live_in = '0;
    @(negedge clk); @(negedge clk);
    check("R6 live gone", DW'(irq_done), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule